// File: doc/BRIEF.md
# Sub-Audio Tone Frequency Meter

This block measures the frequency of an unknown sub-audio tone without being told which tone to expect. Its input is a clean, clock-synchronous square wave at twice the tone frequency, taken after comparison, noise filtering and doubling. The block also takes a slow reference tick derived from the system clock, nominally 4 MHz divided by 960, so about 4166.7 Hz. A measurement window is opened by a rising edge of the doubled tone and runs for a fixed number of ticks: 511 by default, about 122.64 ms. Inside the window the block counts the whole doubled-tone cycles N. It also keeps R, the ticks left between the last counted edge and the end of the window.

At the end of a good window the block packs N and R into a 16-bit result word and sets a measurement-complete flag, which is the interrupt request to the host. The host reads the word high byte first and recovers the frequency as N·f_clk / (1920·(511 − R)), or matches the word against its own table. Over the normal tone range N lies between 16 and 61. For example, a 100 Hz tone gives N = 24, R = 11, and a 250 Hz tone gives N = 61, R = 3. A quality input from an upstream signal assessor must stay high for the whole window, or the window is thrown away.

Top module: `tone_freq_meter`

## Requirements
- R1: While the meter is idle and enabled, a rising edge of `tone_in` (high in a cycle after a low cycle) opens a window in that cycle. A tick in the opening cycle is not counted. The window closes in the cycle that carries its WIN_TICKS-th counted tick.
- R2: N is the number of rising edges after the opening cycle and before the closing cycle, saturating at 63. It is published in result bits 13:8.
- R3: R is WIN_TICKS minus the ticks counted from window opening up to and including the cycle of the last counted edge, saturating at 63. It is published in result bits 5:0. Result bits 15:14 and 7:6 are zero.
- R4: A published result appears in `result` one cycle after the closing cycle. In that same cycle `done_flag` goes high and `new_result` pulses high for one cycle.
- R5: If `quality_ok` is low in any cycle from the opening cycle through the closing cycle, the window publishes nothing. `result` and `done_flag` are then left unchanged.
- R6: A window with N = 0 publishes nothing.
- R7: `done_flag` stays set until a cycle with `status_rd`, `gen_reset` or `enable` low clears it. A publish in the same cycle as `status_rd` leaves the flag set.
- R8: `gen_reset` high or `enable` low aborts an open window. Nothing is published from it.
- R9: `result` changes only on a publish. Reset does not alter it. Reset clears `done_flag` and `new_result`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Decoder powered; low aborts the window and clears the flag |
| gen_reset | input | 1 | General reset pulse; aborts the window and clears the flag |
| status_rd | input | 1 | Status-read pulse; clears the flag |
| tick | input | 1 | One-cycle measurement tick |
| tone_in | input | 1 | Doubled tone, synchronous square wave |
| quality_ok | input | 1 | Upstream signal-quality good |
| result | output | 16 | Packed {2'b0, N, 2'b0, R} |
| new_result | output | 1 | One-cycle pulse on publish |
| done_flag | output | 1 | Measurement-complete status / interrupt request |

## Verification
The main check sweeps the doubled-tone period in steps of four clocks, using a fixed tick spacing, so N runs from about 60 down to 15. Each step is compared against the closed-form N and R, which separates an off-by-one on the closing edge from an off-by-one on the tick span. Very short periods push N into saturation, and a very long period pushes R into saturation while N = 1. A period longer than the window shows that an empty window publishes nothing. Further windows drop quality for one cycle, abort through the enable input or the reset pulse, or read status in the closing cycle; each shows a rule for discarding a result or clearing the flag.

// File: rtl/tfm_pkg.sv
package tfm_pkg;
  localparam int FIELD_W = 6;
  localparam int FIELD_MAX = (1 << FIELD_W) - 1;
  localparam int RESULT_W = 16;

  function automatic logic [FIELD_W-1:0] sat_field(input int unsigned v);
    logic [31:0] w;
    w = v;
    if (v > FIELD_MAX) return FIELD_W'(FIELD_MAX);
    return w[FIELD_W-1:0];
  endfunction

  function automatic int unsigned leftover_ticks(input int unsigned win, input int unsigned span);
    return win - span;
  endfunction

  function automatic logic [RESULT_W-1:0] pack_result(input logic [FIELD_W-1:0] n,
                                                      input logic [FIELD_W-1:0] r);
    return {2'b00, n, 2'b00, r};
  endfunction
endpackage

// File: rtl/tfm_edge.sv
module tfm_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic tone_in,
  output logic rise
);
  logic tone_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tone_q <= 1'b0;
    else        tone_q <= tone_in;
  end

  assign rise = tone_in & ~tone_q;
endmodule

// File: rtl/tfm_window.sv
module tfm_window import tfm_pkg::*; #(
  parameter int WIN_TICKS = 511
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               gen_reset,
  input  logic               tick,
  input  logic               rise,
  input  logic               quality_ok,
  output logic               win_close,
  output logic               win_good,
  output logic [FIELD_W-1:0] win_n,
  output logic [FIELD_W-1:0] win_r,
  output logic               active
);
  localparam int TW = $clog2(WIN_TICKS);
  localparam logic [TW-1:0] LAST = TW'(WIN_TICKS - 1);
  localparam logic [FIELD_W-1:0] NSAT = FIELD_W'(FIELD_MAX);

  logic [TW-1:0]      tick_cnt;
  logic [TW-1:0]      span;
  logic [FIELD_W-1:0] n_cnt;
  logic               qual_held;
  logic               abort;
  logic               close_now;

  assign abort     = gen_reset | ~enable;
  assign close_now = active & tick & (tick_cnt == LAST);
  assign win_close = close_now & ~abort;
  assign win_good  = qual_held & quality_ok & (n_cnt != '0);
  assign win_n     = n_cnt;
  assign win_r     = sat_field(leftover_ticks(WIN_TICKS, 32'(span)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      tick_cnt  <= '0;
      span      <= '0;
      n_cnt     <= '0;
      qual_held <= 1'b0;
    end else if (abort) begin
      active <= 1'b0;
    end else if (!active) begin
      if (rise) begin
        active    <= 1'b1;
        tick_cnt  <= '0;
        span      <= '0;
        n_cnt     <= '0;
        qual_held <= quality_ok;
      end
    end else if (close_now) begin
      active <= 1'b0;
    end else begin
      if (tick) tick_cnt <= tick_cnt + 1'b1;
      qual_held <= qual_held & quality_ok;
      if (rise) begin
        if (n_cnt != NSAT) n_cnt <= n_cnt + 1'b1;
        span <= tick_cnt + TW'(tick);
      end
    end
  end

  // R1: the tick count never passes the last tick of the window
  p_tick_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (tick_cnt <= LAST));
  // R1: a closing window returns to idle
  p_close_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    win_close |=> !active);
  // R8: an abort leaves no window open
  p_abort_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !active);
  // R3: the leftover span can never be zero
  p_span_left_r3: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (span <= LAST));
endmodule

// File: rtl/tfm_result.sv
module tfm_result import tfm_pkg::*; (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                publish,
  input  logic [FIELD_W-1:0]  n_val,
  input  logic [FIELD_W-1:0]  r_val,
  input  logic                clear_req,
  output logic [RESULT_W-1:0] result,
  output logic                done_flag,
  output logic                new_result
);
  always_ff @(posedge clk) begin
    if (publish) result <= pack_result(n_val, r_val);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_flag  <= 1'b0;
      new_result <= 1'b0;
    end else begin
      new_result <= publish;
      if (publish)        done_flag <= 1'b1;
      else if (clear_req) done_flag <= 1'b0;
    end
  end

  // R4: a publish sets the flag and the strobe
  p_publish_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    publish |=> (done_flag && new_result));
  // R7: a clear with no publish drops the flag
  p_clear_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_req && !publish) |=> !done_flag);
  // R9: the word only moves on a publish
  p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !publish |=> $stable(result));
  // R3: pad bits of a fresh word are zero
  p_pad_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    new_result |-> (result[15:14] == 2'b00 && result[7:6] == 2'b00));
endmodule

// File: rtl/tone_freq_meter.sv
module tone_freq_meter import tfm_pkg::*; #(
  parameter int WIN_TICKS = 511
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enable,
  input  logic        gen_reset,
  input  logic        status_rd,
  input  logic        tick,
  input  logic        tone_in,
  input  logic        quality_ok,
  output logic [15:0] result,
  output logic        new_result,
  output logic        done_flag
);
  logic               rise;
  logic               win_close;
  logic               win_good;
  logic [FIELD_W-1:0] win_n;
  logic [FIELD_W-1:0] win_r;
  logic               active;
  logic               publish;
  logic               clear_req;

  tfm_edge u_edge (
    .clk(clk), .rst_n(rst_n), .tone_in(tone_in), .rise(rise)
  );

  tfm_window #(.WIN_TICKS(WIN_TICKS)) u_window (
    .clk(clk), .rst_n(rst_n), .enable(enable), .gen_reset(gen_reset),
    .tick(tick), .rise(rise), .quality_ok(quality_ok),
    .win_close(win_close), .win_good(win_good),
    .win_n(win_n), .win_r(win_r), .active(active)
  );

  assign publish   = win_close & win_good;
  assign clear_req = status_rd | gen_reset | ~enable;

  tfm_result u_result (
    .clk(clk), .rst_n(rst_n), .publish(publish), .n_val(win_n), .r_val(win_r),
    .clear_req(clear_req), .result(result), .done_flag(done_flag),
    .new_result(new_result)
  );

  // R6: an empty window never publishes
  p_empty_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (win_close && win_n == '0) |=> !new_result);
  // R5: a window closing under bad quality stays silent
  p_quality_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (win_close && !quality_ok) |=> !new_result);
endmodule

// File: tb/tone_freq_meter_tb.sv
`timescale 1ns/1ps
module tone_freq_meter_tb;
  localparam int WIN = 511;
  localparam int D = 4;
  localparam int CLOSE_K = WIN * D;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b1, gen_reset = 1'b0, status_rd = 1'b0;
  logic tick = 1'b0, tone_in = 1'b0, quality_ok = 1'b1;
  logic [15:0] result;
  logic new_result, done_flag;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  tone_freq_meter #(.WIN_TICKS(WIN)) u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .gen_reset(gen_reset),
    .status_rd(status_rd), .tick(tick), .tone_in(tone_in),
    .quality_ok(quality_ok), .result(result), .new_result(new_result),
    .done_flag(done_flag)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // clear_mode: 0 enable low, 1 status read, 2 general reset, 3 none
  task automatic run(input int P, input int qdrop_k, input int abort_k,
                     input bit abort_by_reset, input bit rd_at_close, input int clear_mode);
    int n, span, r, en, er;
    bit pub;
    logic [15:0] prev;
    n    = (CLOSE_K - 1) / P;
    span = (n * P) / D;
    r    = WIN - span;
    en   = (n > 63) ? 63 : n;
    er   = (r > 63) ? 63 : r;
    pub  = (n > 0) && (qdrop_k < 0) && (abort_k < 0);
    @(negedge clk);
    tone_in = 1'b0; tick = 1'b0;
    @(negedge clk);
    prev = result;
    for (int k = 0; k <= CLOSE_K + 1; k++) begin
      @(negedge clk);
      if (k == CLOSE_K)
        check(done_flag == 1'b0, "R4 flag before close", int'(done_flag), 0);
      if (k == CLOSE_K + 1) begin
        if (pub) begin
          check(done_flag == 1'b1, "R4 flag after close", int'(done_flag), 1);
          check(new_result == 1'b1, "R4 strobe", int'(new_result), 1);
          check(int'(result[13:8]) == en, "R2 N field", int'(result[13:8]), en);
          check(int'(result[5:0]) == er, "R3 R field", int'(result[5:0]), er);
          check(result[15:14] == 2'b00 && result[7:6] == 2'b00, "R3 pad bits",
                int'(result), int'({2'b00, result[13:8], 2'b00, result[5:0]}));
          if (rd_at_close)
            check(done_flag == 1'b1, "R7 set beats read", int'(done_flag), 1);
        end else begin
          check(done_flag == 1'b0, "R5 R6 R8 no publish", int'(done_flag), 0);
          check(result == prev, "R9 result held", int'(result), int'(prev));
        end
      end
      tick       = (k % D) == 0;
      tone_in    = (k % P) < (P / 2);
      quality_ok = (k != qdrop_k);
      status_rd  = rd_at_close && (k == CLOSE_K);
      enable     = !(k == abort_k && !abort_by_reset);
      gen_reset  = (k == abort_k && abort_by_reset);
    end
    tone_in = 1'b0; tick = 1'b0; status_rd = 1'b0;
    enable = 1'b1; gen_reset = 1'b0; quality_ok = 1'b1;
    if (clear_mode != 3) begin
      @(negedge clk);
      case (clear_mode)
        0: enable = 1'b0;
        1: status_rd = 1'b1;
        default: gen_reset = 1'b1;
      endcase
      @(negedge clk);
      enable = 1'b1; status_rd = 1'b0; gen_reset = 1'b0;
      check(done_flag == 1'b0, "R7 flag cleared", int'(done_flag), 0);
      @(negedge clk);
      enable = 1'b0;
      @(negedge clk);
      enable = 1'b1;
    end
  endtask

  initial begin
    logic [15:0] saved;
    repeat (3) @(negedge clk);
    check(done_flag == 1'b0, "R9 reset flag", int'(done_flag), 0);
    check(new_result == 1'b0, "R9 reset strobe", int'(new_result), 0);
    rst_n = 1'b1;
    // R1 R2 R3: period sweep across the normal N range
    for (int p = 34; p <= 130; p += 4) run(p, -1, -1, 1'b0, 1'b0, p % 3);
    // R2 saturation of N, R3 saturation of R with N = 1
    run(10, -1, -1, 1'b0, 1'b0, 1);
    run(1500, -1, -1, 1'b0, 1'b0, 1);
    // R6: period longer than the window
    run(3000, -1, -1, 1'b0, 1'b0, 0);
    // R5: one-cycle quality drop
    run(60, 700, -1, 1'b0, 1'b0, 0);
    // R8: aborts by enable and by general reset
    run(60, -1, 1000, 1'b0, 1'b0, 0);
    run(60, -1, 900, 1'b1, 1'b0, 0);
    // R7: read in the closing cycle
    run(50, -1, -1, 1'b0, 1'b1, 1);
    // R9: reset keeps the word and clears the flag
    run(70, -1, -1, 1'b0, 1'b0, 3);
    saved = result;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(done_flag == 1'b0, "R9 reset clears flag", int'(done_flag), 0);
    check(result == saved, "R9 reset keeps result", int'(result), int'(saved));
    rst_n = 1'b1;
    @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule